// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block measures the bit period of a known synchronization character arriving on a UART receive line. It turns that measurement into the divisor that a baud rate generator loads. Software requests a measurement with a one-cycle write strobe. The block accepts the request only when the UART is in asynchronous mode and wake-up on break is switched off. While a measurement is pending, the enable status reads high.

The block expects the character 0x55. It is sent least significant bit first, after an idle-high line, so it produces a falling edge every two bit times. Counting starts on the falling edge of the start bit. The block then counts reference ticks up to the fifth falling edge, which is the edge into bit 7. At that point the count is written into the divisor register, the enable status clears itself, and a receive-complete flag rises. A read strobe on the receive-data register clears the flag. If the count would pass its maximum, it saturates and an overflow status bit is set.

Top module: `abaud_detect`

## Requirements
- R1: After reset, enable, rxDone and overflow are 0, and divisor is 0.
- R2: A pulse on enableSet sets enable only when asyncMode is 1 and wakeEnable is 0. In any other case the pulse is ignored: enable stays 0 and no result is produced.
- R3: Accepting a request clears the tick counter and the overflow bit. A result therefore never carries over from an earlier measurement.
- R4: The counter counts ticks during every cycle from the cycle after the first detected falling edge up to and including the cycle of the fifth detected falling edge. For 0x55 sent with B clock cycles per bit and one tick every P cycles (P dividing 8B), the result is 8B/P.
- R5: The receive line passes through a two-flop synchronizer. rxDone rises on the third rising clock edge after the fifth falling edge appears on rxLine.
- R6: On the same clock edge, the divisor is loaded with the result, enable returns to 0 and rxDone goes to 1.
- R7: If the count would go past 2^CNT_W-1, it holds at 2^CNT_W-1 and overflow is set. The saturated value is what gets loaded.
- R8: A pulse on rdStrobe clears rxDone and leaves the divisor unchanged.
- R9: Falling edges on rxLine while enable is 0 have no effect on divisor or rxDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference tick, one-cycle pulses |
| rxLine | input | 1 | Asynchronous receive line, idle high |
| asyncMode | input | 1 | UART configured for asynchronous operation |
| wakeEnable | input | 1 | Wake-up on break enabled (blocks detection) |
| enableSet | input | 1 | Software write strobe that requests a measurement |
| rdStrobe | input | 1 | Read strobe of the receive-data register |
| enable | output | 1 | Measurement pending; clears itself on completion |
| divisor | output | CNT_W | Measured divisor (high and low byte pair) |
| rxDone | output | 1 | Receive-complete flag |
| overflow | output | 1 | Count saturated during the last measurement |

## Verification
The bench builds the block with CNT_W set to 10, so that saturation is reached with a window of a few thousand cycles instead of more than sixty thousand. With that width it sweeps bit lengths from 3 to 24 cycles against tick periods of 1, 2, 4 and 8, and compares every result with 8B/P. A long-bit character pushes the count past 1023, which exercises the saturation and overflow behaviour. The run that follows shows that the counter and the overflow bit are cleared when the next request is accepted.

// File: rtl/abaud_pkg.sv
package abaud_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_MEASURE = 2'd2
  } abState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic countEn;
    logic load;
  } abStrobe_t;
endpackage

// File: rtl/abaud_datapath.sv
module abaud_datapath
  import abaud_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             tick,
  input  abStrobe_t        strb,
  output logic             fallSeen,
  output logic [CNT_W-1:0] divisor,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   rxSync;
  logic [CNT_W-1:0]       cntQ;
  logic [CNT_W-1:0]       nextCnt;
  logic                   satHit;

  assign rxSync = syncQ[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= rxSync;
  end

  assign fallSeen = prevQ & ~rxSync;

  always_comb begin
    nextCnt = cntQ;
    satHit  = 1'b0;
    if (strb.countEn && tick) begin
      if (cntQ == CNT_MAX) satHit  = 1'b1;
      else                 nextCnt = cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      overflow <= 1'b0;
    end else if (strb.clearCnt) begin
      cntQ     <= '0;
      overflow <= 1'b0;
    end else if (strb.countEn) begin
      cntQ <= nextCnt;
      if (satHit) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divisor <= '0;
    else if (strb.load) divisor <= nextCnt;
  end

  // R3: the counter is zero right after a clear
  a_r3_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (cntQ == '0 && !overflow));

  // R7: overflow is only ever seen with the counter held at its maximum
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (cntQ == CNT_MAX));

  // R6: a load captures the count including the current tick
  a_r6_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (divisor == $past(nextCnt)));
endmodule

// File: rtl/abaud_control.sv
module abaud_control
  import abaud_pkg::*;
#(
  parameter int EDGES = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enableSet,
  input  logic      asyncMode,
  input  logic      wakeEnable,
  input  logic      rdStrobe,
  input  logic      fallSeen,
  output abStrobe_t strb,
  output logic      enable,
  output logic      rxDone
);
  localparam int EW = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  abState_t      stateQ;
  logic [EW-1:0] edgeQ;
  logic          accept;
  logic          finish;

  assign accept = enableSet && asyncMode && !wakeEnable && (stateQ == ST_IDLE);
  assign finish = (stateQ == ST_MEASURE) && fallSeen && (edgeQ == LAST_EDGE);

  always_comb begin
    strb          = '0;
    strb.clearCnt = accept;
    strb.countEn  = (stateQ == ST_MEASURE);
    strb.load     = finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      edgeQ  <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (accept) stateQ <= ST_ARMED;
        ST_ARMED: if (fallSeen) begin
          stateQ <= ST_MEASURE;
          edgeQ  <= EW'(1);
        end
        ST_MEASURE: if (fallSeen) begin
          if (edgeQ == LAST_EDGE) stateQ <= ST_IDLE;
          else                    edgeQ  <= edgeQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign enable = (stateQ != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxDone <= 1'b0;
    else if (finish)   rxDone <= 1'b1;
    else if (rdStrobe) rxDone <= 1'b0;
  end

  // R2: enable only rises in a permitted configuration
  a_r2_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> $past(asyncMode && !wakeEnable && enableSet));

  // R6: completion clears enable and raises the flag together
  a_r6_complete: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (!enable && rxDone));

  // R9: the flag never rises without a load
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(strb.load));

  // R8: a read without completion drops the flag
  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strb.load) |=> !rxDone);
endmodule

// File: rtl/abaud_detect.sv
module abaud_detect #(
  parameter int CNT_W       = 16,
  parameter int EDGES       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rxLine,
  input  logic             asyncMode,
  input  logic             wakeEnable,
  input  logic             enableSet,
  input  logic             rdStrobe,
  output logic             enable,
  output logic [CNT_W-1:0] divisor,
  output logic             rxDone,
  output logic             overflow
);
  import abaud_pkg::*;

  abStrobe_t strb;
  logic      fallSeen;

  abaud_control #(.EDGES(EDGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enableSet  (enableSet),
    .asyncMode  (asyncMode),
    .wakeEnable (wakeEnable),
    .rdStrobe   (rdStrobe),
    .fallSeen   (fallSeen),
    .strb       (strb),
    .enable     (enable),
    .rxDone     (rxDone)
  );

  abaud_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .tick     (tick),
    .strb     (strb),
    .fallSeen (fallSeen),
    .divisor  (divisor),
    .overflow (overflow)
  );
endmodule

// File: tb/abaud_detect_bench.sv
module abaud_detect_bench;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick;
  logic rxLine = 1'b1;
  logic asyncMode = 1'b1;
  logic wakeEnable = 1'b0;
  logic enableSet = 1'b0;
  logic rdStrobe = 1'b0;
  logic enable;
  logic [CW-1:0] divisor;
  logic rxDone;
  logic overflow;

  int nChecks = 0;
  int nFail = 0;
  int tickPeriod = 1;
  int tickCnt = 0;
  int cyc = 0;
  int lastFallCyc = 0;
  int riseCyc = -1;
  logic doneSeen = 1'b0;

  always #5 clk = ~clk;

  abaud_detect #(.CNT_W(CW)) u_abaud_detect (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .asyncMode(asyncMode), .wakeEnable(wakeEnable), .enableSet(enableSet),
    .rdStrobe(rdStrobe), .enable(enable), .divisor(divisor),
    .rxDone(rxDone), .overflow(overflow)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tickCnt <= (tickCnt >= tickPeriod - 1) ? 0 : tickCnt + 1;
  end
  assign tick = (tickCnt == 0);

  always @(negedge clk) begin
    if (rxDone && !doneSeen) riseCyc = cyc;
    doneSeen = rxDone;
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseEnable();
    @(negedge clk) enableSet = 1'b1;
    @(negedge clk) enableSet = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  // 0x55, start bit, LSB first, stop bit
  task automatic sendChar(int bitLen);
    logic [9:0] frame = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rxLine && !frame[i]) lastFallCyc = cyc;
      rxLine = frame[i];
      repeat (bitLen - 1) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enable", enable, 0);
    chk("R1 rxDone", rxDone, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 divisor", divisor, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R9 edges with detection idle
    sendChar(5);
    chk("R9 rxDone idle", rxDone, 0);
    chk("R9 divisor idle", divisor, 0);

    // R2 ignored in synchronous mode
    asyncMode = 1'b0;
    pulseEnable();
    chk("R2 enable sync mode", enable, 0);
    sendChar(5);
    chk("R2 rxDone sync mode", rxDone, 0);
    chk("R2 divisor sync mode", divisor, 0);
    asyncMode = 1'b1;

    // R2 ignored with wake-up enabled
    wakeEnable = 1'b1;
    pulseEnable();
    chk("R2 enable wake", enable, 0);
    sendChar(5);
    chk("R2 rxDone wake", rxDone, 0);
    wakeEnable = 1'b0;

    // R4 R6 sweep over bit length and tick period
    for (int p = 1; p <= 8; p = p * 2) begin
      tickPeriod = p;
      for (int b = 3; b <= 24; b++) begin
        pulseRead();
        pulseEnable();
        chk("R2 enable accepted", enable, 1);
        riseCyc = -1;
        sendChar(b);
        chk("R4 divisor", divisor, (8 * b) / p);
        chk("R6 enable cleared", enable, 0);
        chk("R6 rxDone set", rxDone, 1);
        chk("R5 latency", riseCyc - lastFallCyc, 3);
        chk("R7 no overflow", overflow, 0);
      end
    end

    // R8 read clears flag, divisor kept
    pulseRead();
    chk("R8 rxDone cleared", rxDone, 0);
    chk("R8 divisor kept", divisor, (8 * 24) / 8);

    // R7 saturation
    tickPeriod = 1;
    pulseEnable();
    sendChar(200);
    chk("R7 divisor saturated", divisor, (1 << CW) - 1);
    chk("R7 overflow set", overflow, 1);
    chk("R7 rxDone", rxDone, 1);

    // R3 fresh count after overflow
    pulseRead();
    pulseEnable();
    chk("R3 overflow cleared on accept", overflow, 0);
    sendChar(10);
    chk("R3 divisor fresh", divisor, 80);
    chk("R3 overflow stays clear", overflow, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule